// File: doc/BRIEF.md
# LUT Configuration Word Extractor

This block watches a stream of configuration bytes, each carrying its own running byte index. From that stream it collects the 64 configuration bits of one six-input lookup table. A start strobe, given while the block is idle, fixes a slice base offset and a table selection. The bits of one table sit in four two-byte pieces that are spread through the stream at a fixed stride. The block picks those eight bytes out, forms a raw word, and reorders it into truth-table order with a fixed permutation.

When collection completes, the block pulses `done`. Together with the pulse it presents the reordered word and a flag that tells the two kinds of function apart. Either the table is one six-input function, or it holds two five-input functions, one for each value of the sixth input. If the stream ends before all eight bytes have been seen, the block raises an error pulse instead. A combinational evaluation port reads back the held truth table for any input vector.

Top module: `lut_word_extract`

## Requirements
- R1: After reset, `busy`, `done`, `incomplete`, `two_out` and all bits of `word_out` are 0.
- R2: A `start` seen while idle captures `slice_base` and `lut_sel`, and `busy` is 1 from the next cycle. A `start` seen while busy is ignored, and the job in progress keeps its original selection and offset.
- R3: `lut_sel` encodes tables A=0, B=1, C=2, D=3. Their storage slots are B→0, A→1, D→2, C→3. The start offset is `slice_base + 2*slot`.
- R4: Piece p (p=0..3) occupies byte indices `start + 404*p` and `start + 404*p + 1`. The first byte taken becomes raw bits 63..56, with its bit 7 as raw bit 63, and each later byte fills the next lower eight bits. Bytes at any other index, and all beats while idle, are ignored.
- R5: Truth-table row r = A1 + 2·A2 + 4·A3 + 8·A4 + 16·A5 + 32·A6 takes raw bit `b(A1,A4) - A2 - 2·A3 - 4·(A5 + 2·A6)`. Here b is 63 for (A1=0, A4=0), 47 for (1,0), 15 for (0,1) and 31 for (1,1).
- R6: `word_out` bit 63−r holds row r. A raw word 0x3C033C033C033C03 yields 0x0F0FF0F000000F0F.
- R7: `done` is a one-cycle pulse in the cycle after the beat that carries the eighth selected byte. `busy` is 0 in that cycle, and `word_out` and `two_out` are updated with it.
- R8: With `done`, `two_out` is 1 exactly when rows 0..31 differ from rows 32..63.
- R9: A beat with `in_last` while busy that does not carry the eighth byte produces a one-cycle `incomplete` pulse, ends the job with no `done`, and leaves `word_out` and `two_out` unchanged.
- R10: `eval_o6` = row {A6..A1} and `eval_o5` = row {0,A5..A1} of the held word, both combinational from `eval_a` (bit 0 is A1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (acted on only while idle) |
| slice_base | input | IDX_W | Byte offset of the slice's first table slot |
| lut_sel | input | 2 | Table to extract: A=0, B=1, C=2, D=3 |
| in_valid | input | 1 | Stream beat valid |
| in_byte | input | 8 | Stream byte |
| in_idx | input | IDX_W | Running byte index of this beat |
| in_last | input | 1 | Final beat of the stream |
| busy | output | 1 | A job is collecting bytes |
| done | output | 1 | One-cycle completion pulse |
| incomplete | output | 1 | One-cycle pulse: stream ended early |
| word_out | output | 64 | Permuted truth table, row r at bit 63−r |
| two_out | output | 1 | Table holds two five-input functions |
| eval_a | input | 6 | Evaluation vector, bit 0 = A1 |
| eval_o6 | output | 1 | Row {A6..A1} of the held table |
| eval_o5 | output | 1 | Row {0,A5..A1} of the held table |

## Verification
The in-design properties assume that `start` arrives only as a pulse and that target bytes come in rising index order within one stream. They also assume a stream carries at most one `in_last`, and only after `start`. The scoreboard stimulus keeps to these assumptions. Each job is driven as one gap-free index run from zero. A stray `start` is injected only in the middle of a stream, where it must be ignored, and the filler bytes between pieces are varied so that a wrong index match would corrupt the word.

// File: rtl/lwx_pkg.sv
package lwx_pkg;

   localparam int WORD_W = 64;
   localparam int ROW_W  = 6;

   // raw bit index feeding truth-table row r
   function automatic int row_src(input int r);
      int a1, a2, a3, a4, grp, base;
      a1  = r & 1;
      a2  = (r >> 1) & 1;
      a3  = (r >> 2) & 1;
      a4  = (r >> 3) & 1;
      grp = (r >> 4) & 3;
      if (a4 == 0) base = (a1 == 1) ? 47 : 63;
      else         base = (a1 == 1) ? 31 : 15;
      return base - a2 - 2 * a3 - 4 * grp;
   endfunction

endpackage

// File: rtl/lwx_gather.sv
module lwx_gather #(
   parameter int IDX_W       = 20,
   parameter int STRIDE      = 404,
   parameter int PIECES      = 4,
   parameter int PIECE_BYTES = 2,
   parameter int SLOT_BYTES  = 2,
   parameter bit SWAP_ORDER  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [IDX_W-1:0]          slice_base,
   input  logic [1:0]                lut_sel,
   input  logic                      in_valid,
   input  logic [7:0]                in_byte,
   input  logic [IDX_W-1:0]          in_idx,
   input  logic                      in_last,
   output logic                      busy,
   output logic [lwx_pkg::WORD_W-1:0] raw_full,
   output logic                      fin,
   output logic                      err
);
   import lwx_pkg::*;

   localparam int NBYTES = PIECES * PIECE_BYTES;
   localparam int CW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
   localparam int PW     = (PIECE_BYTES > 1) ? $clog2(PIECE_BYTES) : 1;
   localparam logic [IDX_W-1:0] JUMP = IDX_W'(STRIDE - (PIECE_BYTES - 1));

   if (NBYTES * 8 != WORD_W) begin : g_bad_size
      $error("pieces times piece bytes must cover exactly one 64-bit word");
   end
   if (STRIDE < PIECE_BYTES) begin : g_bad_stride
      $error("stride must not be shorter than a piece");
   end

   logic [1:0] slot;
   if (SWAP_ORDER) begin : g_pair_swap
      assign slot = {lut_sel[1], ~lut_sel[0]};
   end else begin : g_linear
      assign slot = lut_sel;
   end

   logic              busy_q;
   logic [IDX_W-1:0]  nxt_q;
   logic [CW-1:0]     cnt_q;
   logic [PW-1:0]     bpos_q;
   logic [WORD_W-1:0] raw_q;
   logic              hit;

   assign hit  = busy_q && in_valid && (in_idx == nxt_q);
   assign fin  = hit && (cnt_q == CW'(NBYTES - 1));
   assign err  = busy_q && in_valid && in_last && !fin;
   assign busy = busy_q;

   always_comb begin
      raw_full = raw_q;
      if (hit) raw_full[WORD_W - 1 - 8 * int'(cnt_q) -: 8] = in_byte;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         nxt_q  <= '0;
         cnt_q  <= '0;
         bpos_q <= '0;
         raw_q  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            nxt_q  <= slice_base + IDX_W'(slot) * IDX_W'(SLOT_BYTES);
            cnt_q  <= '0;
            bpos_q <= '0;
            raw_q  <= '0;
         end
      end else begin
         if (hit) begin
            raw_q <= raw_full;
            cnt_q <= cnt_q + CW'(1);
            if (bpos_q == PW'(PIECE_BYTES - 1)) begin
               bpos_q <= '0;
               nxt_q  <= nxt_q + JUMP;
            end else begin
               bpos_q <= bpos_q + PW'(1);
               nxt_q  <= nxt_q + IDX_W'(1);
            end
         end
         if (fin || err) busy_q <= 1'b0;
      end
   end

   // R4
   idle_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |=> (raw_q == $past(raw_q)) || busy_q);

endmodule

// File: rtl/lwx_permute.sv
module lwx_permute (
   input  logic [lwx_pkg::WORD_W-1:0] raw,
   output logic [lwx_pkg::WORD_W-1:0] table_word
);
   import lwx_pkg::*;

   for (genvar r = 0; r < WORD_W; r++) begin : g_row
      localparam int SRC = row_src(r);
      assign table_word[WORD_W - 1 - r] = raw[SRC];
   end

endmodule

// File: rtl/lwx_eval.sv
module lwx_eval (
   input  logic [lwx_pkg::WORD_W-1:0] table_word,
   input  logic [lwx_pkg::ROW_W-1:0]  a,
   output logic                       o6,
   output logic                       o5
);
   import lwx_pkg::*;

   logic [ROW_W-1:0] pos6, pos5;

   // row r lives at bit 63-r, which is the bitwise inverse of r
   assign pos6 = ~a;
   assign pos5 = ~{1'b0, a[ROW_W-2:0]};
   assign o6   = table_word[pos6];
   assign o5   = table_word[pos5];

endmodule

// File: rtl/lut_word_extract.sv
module lut_word_extract #(
   parameter int IDX_W       = 20,
   parameter int STRIDE      = 404,
   parameter int PIECES      = 4,
   parameter int PIECE_BYTES = 2,
   parameter int SLOT_BYTES  = 2,
   parameter bit SWAP_ORDER  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] slice_base,
   input  logic [1:0]       lut_sel,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   input  logic [IDX_W-1:0] in_idx,
   input  logic             in_last,
   output logic             busy,
   output logic             done,
   output logic             incomplete,
   output logic [63:0]      word_out,
   output logic             two_out,
   input  logic [5:0]       eval_a,
   output logic             eval_o6,
   output logic             eval_o5
);
   import lwx_pkg::*;

   localparam int HALF = WORD_W / 2;

   logic [WORD_W-1:0] raw_full, perm_next, word_q;
   logic              fin, err, done_q, err_q, two_q;

   lwx_gather #(
      .IDX_W(IDX_W), .STRIDE(STRIDE), .PIECES(PIECES),
      .PIECE_BYTES(PIECE_BYTES), .SLOT_BYTES(SLOT_BYTES), .SWAP_ORDER(SWAP_ORDER)
   ) u_gather (
      .clk(clk), .rst_n(rst_n), .start(start), .slice_base(slice_base),
      .lut_sel(lut_sel), .in_valid(in_valid), .in_byte(in_byte),
      .in_idx(in_idx), .in_last(in_last), .busy(busy),
      .raw_full(raw_full), .fin(fin), .err(err)
   );

   lwx_permute u_perm (.raw(raw_full), .table_word(perm_next));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         word_q <= '0;
         two_q  <= 1'b0;
      end else begin
         done_q <= fin;
         err_q  <= err;
         if (fin) begin
            word_q <= perm_next;
            two_q  <= (perm_next[WORD_W-1:HALF] != perm_next[HALF-1:0]);
         end
      end
   end

   lwx_eval u_eval (.table_word(word_q), .a(eval_a), .o6(eval_o6), .o5(eval_o5));

   assign done       = done_q;
   assign incomplete = err_q;
   assign word_out   = word_q;
   assign two_out    = two_q;

   // R9
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && incomplete));

   // R7
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R9
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(word_out));

   // R10
   single_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !two_out |-> (eval_o6 == eval_o5));

endmodule

// File: tb/sim_lut_word_extract.sv
module sim_lut_word_extract;

   localparam int IDX_W = 20;

   typedef struct packed {
      logic [63:0] word;
      logic        two;
      logic        err;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [IDX_W-1:0] slice_base = '0;
   logic [1:0]       lut_sel = '0;
   logic             in_valid = 1'b0;
   logic [7:0]       in_byte = '0;
   logic [IDX_W-1:0] in_idx = '0;
   logic             in_last = 1'b0;
   logic             busy, done, incomplete, two_out, eval_o6, eval_o5;
   logic [63:0]      word_out;
   logic [5:0]       eval_a = '0;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   exp_t sb[$];
   logic [63:0] held_word = '0;
   logic        held_two  = 1'b0;

   // raw bit feeding each truth-table row, rows 0..63
   int tab [64] = '{
      63,47,62,46,61,45,60,44,15,31,14,30,13,29,12,28,
      59,43,58,42,57,41,56,40,11,27,10,26, 9,25, 8,24,
      55,39,54,38,53,37,52,36, 7,23, 6,22, 5,21, 4,20,
      51,35,50,34,49,33,48,32, 3,19, 2,18, 1,17, 0,16};

   lut_word_extract u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .slice_base(slice_base),
      .lut_sel(lut_sel), .in_valid(in_valid), .in_byte(in_byte),
      .in_idx(in_idx), .in_last(in_last), .busy(busy), .done(done),
      .incomplete(incomplete), .word_out(word_out), .two_out(two_out),
      .eval_a(eval_a), .eval_o6(eval_o6), .eval_o5(eval_o5)
   );

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [63:0] permute(input logic [63:0] raw);
      logic [63:0] w;
      for (int r = 0; r < 64; r++) w[63 - r] = raw[tab[r]];
      return w;
   endfunction

   function automatic logic [63:0] unpermute(input logic [63:0] w);
      logic [63:0] raw = '0;
      for (int r = 0; r < 64; r++) raw[tab[r]] = w[63 - r];
      return raw;
   endfunction

   function automatic int slot_of(input logic [1:0] sel);
      case (sel)
         2'd0: return 1;
         2'd1: return 0;
         2'd2: return 3;
         default: return 2;
      endcase
   endfunction

   // monitor: pops expected results as the design produces them
   always @(negedge clk) begin
      if (rst_n && (done || incomplete)) begin
         if (sb.size() == 0) begin
            check(1'b0, "R7 unexpected result", {62'd0, done, incomplete}, 64'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (e.err) begin
               check(incomplete && !done, "R9 incomplete pulse", {63'd0, incomplete}, 64'd1);
               check(word_out == held_word, "R9 word unchanged", word_out, held_word);
               check(two_out == held_two, "R9 flag unchanged", {63'd0, two_out}, {63'd0, held_two});
            end else begin
               check(done && !incomplete && !busy, "R7 done pulse", {62'd0, done, busy}, 64'd2);
               check(word_out == e.word, "R5 R6 permuted word", word_out, e.word);
               check(two_out == e.two, "R8 two-output flag", {63'd0, two_out}, {63'd0, e.two});
               held_word = e.word;
               held_two  = e.two;
            end
         end
      end
   end

   task automatic run_job(input logic [1:0] sel, input logic [IDX_W-1:0] base,
                          input logic [63:0] raw, input bit short_run, input bit poke);
      int st, end_idx;
      exp_t e;
      @(negedge clk);
      start = 1'b1; slice_base = base; lut_sel = sel;
      @(negedge clk);
      start = 1'b0;
      st = int'(base) + 2 * slot_of(sel);
      e.err  = short_run;
      e.word = permute(raw);
      e.two  = (e.word[63:32] != e.word[31:0]);
      sb.push_back(e);
      end_idx = short_run ? st + 2 * 404 + 4 : st + 3 * 404 + 4;
      for (int i = 0; i <= end_idx; i++) begin
         logic [7:0] b;
         b = 8'((i * 13 + 7) ^ (i >> 3));
         for (int k = 0; k < 8; k++)
            if (i == st + (k / 2) * 404 + (k % 2)) b = raw[63 - 8 * k -: 8];
         in_valid = 1'b1; in_idx = IDX_W'(i); in_byte = b; in_last = (i == end_idx);
         if (poke && i == 5) begin
            start = 1'b1; lut_sel = sel ^ 2'd1; slice_base = base + 7;
         end
         @(negedge clk);
         start = 1'b0;
      end
      in_valid = 1'b0; in_last = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(sb.size() == 0, "R7 result produced", 64'(sb.size()), 64'd0);
      check(!busy, "R2 idle after job", {63'd0, busy}, 64'd0);
   endtask

   task automatic check_eval(input logic [63:0] w);
      for (int a = 0; a < 64; a++) begin
         eval_a = 6'(a);
         #1;
         check(eval_o6 == w[63 - a], "R10 o6", {63'd0, eval_o6}, {63'd0, w[63 - a]});
         check(eval_o5 == w[63 - (a & 31)], "R10 o5", {63'd0, eval_o5}, {63'd0, w[63 - (a & 31)]});
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy && !done && !incomplete && !two_out, "R1 reset flags",
            {60'd0, busy, done, incomplete, two_out}, 64'd0);
      check(word_out == 64'd0, "R1 reset word", word_out, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R4 beats while idle are ignored
      in_valid = 1'b1; in_idx = '0; in_byte = 8'hFF;
      @(negedge clk);
      in_valid = 1'b0;
      check(!busy && word_out == 64'd0, "R4 idle ignore", word_out, 64'd0);

      // R6 worked example, table C (slot 3), R3 offset
      run_job(2'd2, 20'd100, 64'h3C033C033C033C03, 1'b0, 1'b0);
      check(word_out == 64'h0F0FF0F000000F0F, "R6 worked example", word_out, 64'h0F0FF0F000000F0F);
      check_eval(word_out);

      // R8 single function: halves equal, table A (slot 1)
      run_job(2'd0, 20'd0, unpermute(64'h6996A55A6996A55A), 1'b0, 1'b0);
      check(!two_out, "R8 single output", {63'd0, two_out}, 64'd0);
      check_eval(64'h6996A55A6996A55A);

      // R3 table B (slot 0) with R2 stray start mid-stream
      run_job(2'd1, 20'd37, 64'hDEADBEEF01234567, 1'b0, 1'b1);
      check_eval(permute(64'hDEADBEEF01234567));

      // R3 table D (slot 2)
      run_job(2'd3, 20'd211, 64'h8000000000000001, 1'b0, 1'b0);

      // R9 stream ends after three pieces
      run_job(2'd0, 20'd50, 64'hFFFF0000AAAA5555, 1'b1, 1'b0);
      check_eval(held_word);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule